// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Switch Select Register

This block turns a slow serial control stream into eight parallel switch-select bits. A host presents a data bit and a shift clock. On each rising edge of the shift clock the bit is loaded into an eight-stage register, and the bits already there move up by one stage. A bank of eight latches sits between the register and the select outputs. While the active-low latch control is low, the latches are transparent. On its rising edge they capture the register contents, and they then hold that value while the control stays high. A clear input drives every select to its default throw and takes priority over all other inputs. The last register stage is brought out as a serial output, so that several devices can share one shift clock in a chain.

The four serial-side inputs are asynchronous to the block. Each one passes through a synchronizer into a system clock that runs at least four times faster than the shift clock. Rising edges of the shift clock and of the latch control are found from the synchronized samples. Each select bit picks one of two throws of a single-pole double-throw switch. Level shifting and the switches themselves live outside this block.

Top module: `sws_shift_latch_top`

## Requirements
- R1: While reset is asserted and right after it is released, every select bit and the serial output are 0.
- R2: On each detected rising edge of the shift clock, the data bit goes into stage 0 and every other stage takes the value of the stage below it. After eight bits have been sent most-significant first, select bit k equals bit k of the byte sent, so the first bit sent controls channel 7.
- R3: While the synchronized latch control is low and clear is low, the select bits equal the register contents. This includes the time while shifting is in progress.
- R4: On the rising edge of the latch control, the latches capture the register contents. While the control then stays high, shifting has no effect on the select bits.
- R5: While the synchronized clear is high, all select bits are 0, which is the default throw, whatever the other inputs do. A select value of 1 picks the other throw. Clear does not alter the register. After clear is released with the latch control high, the selects stay at 0.
- R6: The serial output equals register stage 7. A second device whose data input is driven by this output and whose shift clock is shared receives the byte that was shifted out.
- R7: A shift-clock rise that is present at system clock edge t becomes visible on the register, the selects and the serial output right after edge t+2. Before that edge nothing has changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the shift clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data bit (asynchronous) |
| latch_n_i | input | 1 | Active-low transparent latch control |
| clear_i | input | 1 | Active-high clear of all selects |
| sel_o | output | N_STAGES | Switch selects, 1 = alternate throw, 0 = default throw |
| ser_out_o | output | 1 | Last register stage, for cascading |

## Verification
The assertions assume that the shift clock stays high and low for several system cycles each. They also assume that the data bit is stable for two system cycles on each side of a shift-clock rise, so the synchronized data matches the bit intended for that edge. The stimulus holds each shift-clock level for four system cycles and changes data only together with a falling shift clock. It changes latch and clear only while the shift clock is steady. The cascaded second device relies on the same spacing: its data input changes only three cycles after a rise, well before the next rise.

// File: rtl/sws_pkg.sv
package sws_pkg;
  // Serial-side control word, carried through the synchronizer as one vector.
  typedef struct packed {
    logic clear;
    logic latch_n;
    logic sdat;
    logic sclk;
  } sws_ctl_t;

  localparam int unsigned CTL_W = $bits(sws_ctl_t);

  // Rising-edge test on a synchronized level and its previous sample.
  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[DEPTH-1];
  end

  assign sync_o = stage_q[DEPTH-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/sws_shift_reg.sv
module sws_shift_reg #(
  parameter int unsigned N_STAGES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_i,
  output logic [N_STAGES-1:0] q_o
);
  logic [N_STAGES-1:0] q;

  function automatic logic [N_STAGES-1:0] push_bit(input logic [N_STAGES-1:0] cur,
                                                   input logic b);
    return {cur[N_STAGES-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= push_bit(q, bit_i);
  end

  assign q_o = q;
endmodule

// File: rtl/sws_latch_bank.sv
module sws_latch_bank #(
  parameter int unsigned N_STAGES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                latch_n,
  input  logic                capture,
  input  logic [N_STAGES-1:0] d_i,
  output logic [N_STAGES-1:0] sel_o
);
  logic [N_STAGES-1:0] held_q;

  // Holding applies only once the capture edge has passed.
  function automatic logic [N_STAGES-1:0] pick_sel(input logic clr, input logic hold,
                                                   input logic [N_STAGES-1:0] held,
                                                   input logic [N_STAGES-1:0] live);
    if (clr)       return '0;
    else if (hold) return held;
    else           return live;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   held_q <= '0;
    else if (clear)               held_q <= '0;
    else if (!latch_n || capture) held_q <= d_i;
  end

  assign sel_o = pick_sel(clear, latch_n && !capture, held_q, d_i);
endmodule

// File: rtl/sws_shift_latch_top.sv
module sws_shift_latch_top
  import sws_pkg::*;
#(
  parameter int unsigned N_STAGES   = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk_i,
  input  logic                ser_data_i,
  input  logic                latch_n_i,
  input  logic                clear_i,
  output logic [N_STAGES-1:0] sel_o,
  output logic                ser_out_o
);
  localparam int unsigned LAST = N_STAGES - 1;

  sws_ctl_t raw_ctl, syn_ctl, prv_ctl;

  assign raw_ctl = '{clear: clear_i, latch_n: latch_n_i, sdat: ser_data_i, sclk: ser_clk_i};

  sws_sync #(.WIDTH(CTL_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_ctl),
    .sync_o (syn_ctl),
    .prev_o (prv_ctl)
  );

  // Named internal events, also used by the checker.
  logic                shift_evt, latch_evt, clear_s, latch_n_s, data_s;
  logic [N_STAGES-1:0] shreg;

  assign shift_evt = rose(syn_ctl.sclk, prv_ctl.sclk);
  assign latch_evt = rose(syn_ctl.latch_n, prv_ctl.latch_n);
  assign clear_s   = syn_ctl.clear;
  assign latch_n_s = syn_ctl.latch_n;
  assign data_s    = syn_ctl.sdat;

  sws_shift_reg #(.N_STAGES(N_STAGES)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_evt),
    .bit_i   (data_s),
    .q_o     (shreg)
  );

  sws_latch_bank #(.N_STAGES(N_STAGES)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear_s),
    .latch_n(latch_n_s),
    .capture(latch_evt),
    .d_i    (shreg),
    .sel_o  (sel_o)
  );

  assign ser_out_o = shreg[LAST];
endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
  parameter int unsigned N_STAGES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shift_evt,
  input logic                latch_evt,
  input logic                clear_s,
  input logic                latch_n_s,
  input logic                data_s,
  input logic [N_STAGES-1:0] shreg,
  input logic [N_STAGES-1:0] sel_o,
  input logic                ser_out_o
);
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (sel_o == '0 && !ser_out_o));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (shreg[0] == $past(data_s) &&
                   shreg[N_STAGES-1:1] == $past(shreg[N_STAGES-2:0])));

  a_r2_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(shreg));

  a_r3_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_n_s && !clear_s) |-> sel_o == shreg);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_n_s && !latch_evt && !clear_s) |-> sel_o == $past(sel_o));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_s |-> sel_o == '0);

  a_r6_serial_out: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out_o == shreg[N_STAGES-1]);
endmodule

bind sws_shift_latch_top sws_checker #(.N_STAGES(N_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_evt(shift_evt),
  .latch_evt(latch_evt),
  .clear_s  (clear_s),
  .latch_n_s(latch_n_s),
  .data_s   (data_s),
  .shreg    (shreg),
  .sel_o    (sel_o),
  .ser_out_o(ser_out_o)
);

// File: tb/tb_sws_shift_latch_top.sv
module tb_sws_shift_latch_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, le_n = 1'b1, clr = 1'b0;
  logic [7:0] sel_a, sel_b;
  logic       so_a, so_b;

  always #2 clk = ~clk;  // 250 MHz

  sws_shift_latch_top dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_data_i(sdi),
    .latch_n_i(le_n), .clear_i(clr), .sel_o(sel_a), .ser_out_o(so_a));

  sws_shift_latch_top dut_tail (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_data_i(so_a),
    .latch_n_i(le_n), .clear_i(clr), .sel_o(sel_b), .ser_out_o(so_b));

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference: history of inputs as sampled at each edge
  // ({clear, latch_n, data, sclk}), newest first; two chained byte registers.
  bit [3:0] hist[$] = '{4'h0, 4'h0, 4'h0};
  bit [7:0] m0 = 0, m1 = 0, l0 = 0, l1 = 0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      hist = '{4'h0, 4'h0, 4'h0};
      m0 = 0; m1 = 0; l0 = 0; l1 = 0;
    end else begin
      bit [3:0] a2, a3;
      a2 = hist[1];
      a3 = hist[2];
      if (a2[3]) begin l0 = 0; l1 = 0; end
      else if (!a2[2] || !a3[2]) begin l0 = m0; l1 = m1; end
      if (a2[0] && !a3[0]) begin
        m1 = {m1[6:0], m0[7]};
        m0 = {m0[6:0], a2[1]};
      end
      hist.push_front({clr, le_n, sdi, sck});
      void'(hist.pop_back());
    end
    begin
      bit c, hold;
      c    = hist[1][3];
      hold = hist[1][2] && hist[2][2];
      // R7: cycle-exact comparison against the model on every edge
      check({cur_req, "/R7"}, sel_a, c ? 8'h00 : (hold ? l0 : m0));
      check({cur_req, "/R7"}, sel_b, c ? 8'h00 : (hold ? l1 : m1));
      check("R6", {7'b0, so_a}, {7'b0, m0[7]});
      check("R6", {7'b0, so_b}, {7'b0, m1[7]});
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sck = 1'b0; sdi = b;
    wait_cyc(4);
    sck = 1'b1;
    wait_cyc(3);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  initial begin
    logic [7:0] r1, r2, v;
    wait_cyc(5);
    check("R1", sel_a, 8'h00);
    check("R1", {7'b0, so_a}, 8'h00);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1", sel_b, 8'h00);

    cur_req = "R4";
    send_byte(8'hA5);
    send_byte(8'h3C);
    wait_cyc(6);
    check("R4", sel_a, 8'h00);
    check("R4", sel_b, 8'h00);

    cur_req = "R3";
    le_n = 1'b0; wait_cyc(6);
    check("R2", sel_a, 8'h3C);
    check("R6", sel_b, 8'hA5);
    le_n = 1'b1; wait_cyc(4);

    cur_req = "R4";
    r1 = 8'($urandom); r2 = 8'($urandom);
    send_byte(r1); send_byte(r2);
    wait_cyc(6);
    check("R4", sel_a, 8'h3C);
    check("R4", sel_b, 8'hA5);

    cur_req = "R3";
    le_n = 1'b0; wait_cyc(4);
    check("R3", sel_a, r2);
    send_byte(8'h81);
    wait_cyc(6);
    check("R3", sel_a, 8'h81);
    check("R6", sel_b, r2);
    check("R6", {7'b0, so_a}, 8'h01);

    cur_req = "R5";
    clr = 1'b1; wait_cyc(6);
    check("R5", sel_a, 8'h00);
    send_byte(8'h5A);
    wait_cyc(6);
    check("R5", sel_a, 8'h00);
    check("R5", sel_b, 8'h00);
    clr = 1'b0; wait_cyc(6);
    check("R5", sel_a, 8'h5A);
    check("R5", sel_b, 8'h81);
    le_n = 1'b1; wait_cyc(4);
    clr = 1'b1; wait_cyc(4);
    clr = 1'b0; wait_cyc(6);
    check("R5", sel_a, 8'h00);
    le_n = 1'b0; wait_cyc(6);

    cur_req = "R7";
    v = sel_a;
    @(negedge clk); sck = 1'b0; sdi = 1'b1;
    wait_cyc(4);
    sck = 1'b1;
    wait_cyc(2);
    check("R7", sel_a, v);
    wait_cyc(1);
    check("R7", sel_a, {v[6:0], 1'b1});
    wait_cyc(4);

    cur_req = "R2";
    for (int k = 0; k < 4; k++) begin
      r1 = 8'($urandom);
      le_n = 1'b1;
      send_byte(r1);
      wait_cyc(4);
      le_n = 1'b0; wait_cyc(5);
      check("R2", sel_a, r1);
    end

    wait_cyc(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule